// File: doc/BRIEF.md
# Sticky Fault Status Register

This block keeps a 64-bit record of the error events that nearby checking logic reports. Each error type owns one sticky bit. Once an event sets that bit, it stays set until software clears it by writing a one to that bit position. The same register also holds three other things. A multiple-error flag marks a repeated error of a serious class. A privilege capture bit copies the processor privilege level when an error is logged. A software-owned flag bit is written directly.

Error sources pulse one line per error type. Each pulse carries a two-bit class: hardware-corrected, software-correctable or uncorrectable. Events also carry a beat tag that names the 16-byte subunit of the 64-byte bus transaction they belong to, and a transaction-start pulse marks each new transaction. For bus ECC error types, only errors in the first subunit that reports an error are logged. Errors in later subunits of the same transaction are dropped.

Two syndrome fields come from a companion capture block. They appear in the register as read-only views of their inputs. The whole register is visible at all times on a read port. An any-error output summarises the sticky bits.

Top module: `fault_status_reg`

## Requirements
- R1: Out of reset the whole status word is zero. A pulse on `err_valid[i]` sets sticky bit 33+i (types 0..18 map to bits 33..51) in the cycle after the pulse. The bit then stays set through later cycles with no clear.
- R2: A write (`sw_wr`=1) with a one in `sw_wdata` bit k, for k in 51:33, clears sticky bit k in the next cycle. Sticky bits written with zero keep their value.
- R3: If a set event and a write-one clear hit the same sticky bit in the same cycle, the bit ends up set.
- R4: Class encoding per type i on `err_cls[2i+1:2i]` is 00 hardware-corrected, 01 software-correctable, 10 or 11 uncorrectable. Bit 53 (multiple-error) sets when a logged class 01/10/11 event arrives on a type whose sticky bit is already set. Writing a one to bit 53 clears it.
- R5: A logged class 00 event on a type whose sticky bit is already set leaves bit 53 unchanged.
- R6: Bus ECC types are indices 0, 1, 12, 13, 14 and 15. `err_beat` holds the subunit number (0..3). A `txn_start` pulse opens a new transaction and applies to the events of its own cycle. After the first logged bus ECC event of a transaction, bus ECC events with a different beat number are dropped: they set no sticky bit and do not set bit 53. Non-bus types are never dropped.
- R7: When any event is logged, bit 52 takes the value of `priv_in` for that cycle. In cycles with no logged event, writing a one to bit 52 clears it.
- R8: Bits 19:16 always show `msyn_in` and bits 8:0 always show `esyn_in`. Writes have no effect on them.
- R9: A write loads bit 63 directly from `sw_wdata[63]`. Bits 62:54, 32:20 and 15:9 always read zero.
- R10: `any_err` is 1 exactly when at least one of bits 51:33 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 19 | One event pulse per error type |
| err_cls | input | 38 | Two-bit class per error type |
| err_beat | input | 2 | Subunit number of the current bus beat |
| txn_start | input | 1 | Marks the start of a new 64-byte transaction |
| priv_in | input | 1 | Current privilege state |
| msyn_in | input | 4 | Tag syndrome from the capture block |
| esyn_in | input | 9 | Data syndrome from the capture block |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data |
| status | output | 64 | Current register contents |
| any_err | output | 1 | OR of the sticky error bits |

## Verification
The bench builds the block with its default parameters: nineteen error types, four 16-byte subunits per transaction, and a bus ECC mask that covers types 0, 1 and 12 to 15. With these values it can drive a bus type and a non-bus type into the same locked subunit window, so that dropping is shown to affect only the masked types. It also checks that an uncorrectable repeat in a dropped beat leaves the multiple-error flag clear. With the default field layout it can write all ones to the register and confirm that the syndrome views, the reserved zeros and the direct-write flag each keep their own rule.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int REG_W      = 64;
    localparam int N_TYPES    = 19;
    localparam int STICKY_LSB = 33;
    localparam int SUBUNITS   = 4;
    localparam int MSYN_W     = 4;
    localparam int ESYN_W     = 9;
    localparam logic [N_TYPES-1:0] BUS_ECC_TYPES = 19'h0F003;

    typedef enum logic [1:0] {
        CLS_HW_FIXED = 2'b00,
        CLS_SW_FIX   = 2'b01,
        CLS_FATAL    = 2'b10,
        CLS_FATAL_X  = 2'b11
    } err_cls_e;

    // Layout of the status word, most significant field first.
    typedef struct packed {
        logic                sw_flag;   // 63
        logic [8:0]          zero_hi;   // 62:54
        logic                multi;     // 53
        logic                priv;      // 52
        logic [N_TYPES-1:0]  sticky;    // 51:33
        logic [12:0]         zero_mid;  // 32:20
        logic [MSYN_W-1:0]   msyn;      // 19:16
        logic [6:0]          zero_lo;   // 15:9
        logic [ESYN_W-1:0]   esyn;      // 8:0
    } fsr_word_t;

    function automatic logic cls_is_serious(input logic [1:0] cls);
        return err_cls_e'(cls) != CLS_HW_FIXED;
    endfunction

endpackage

// File: rtl/fsr_beat_filter.sv
module fsr_beat_filter #(
    parameter int N        = 19,
    parameter int SUBUNITS = 4,
    parameter logic [N-1:0] BUS_MASK = '0,
    localparam int BEAT_W  = (SUBUNITS > 1) ? $clog2(SUBUNITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [BEAT_W-1:0] beat,
    input  logic [N-1:0]      raw_valid,
    output logic [N-1:0]      accepted
);

    logic              locked_q;
    logic [BEAT_W-1:0] lock_beat_q;
    logic              lock_live;
    logic              beat_ok;
    logic [N-1:0]      bus_hit;

    // A new transaction releases the lock for its own beat.
    assign lock_live = locked_q && !txn_start;
    assign beat_ok   = !lock_live || (beat == lock_beat_q);

    for (genvar i = 0; i < N; i++) begin : g_pass
        if (BUS_MASK[i]) begin : g_bus
            assign accepted[i] = raw_valid[i] && beat_ok;
        end else begin : g_plain
            assign accepted[i] = raw_valid[i];
        end
    end

    assign bus_hit = accepted & BUS_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q    <= 1'b0;
            lock_beat_q <= '0;
        end else if (|bus_hit) begin
            locked_q    <= 1'b1;
            lock_beat_q <= beat;
        end else if (txn_start) begin
            locked_q    <= 1'b0;
        end
    end

    // R6: a held lock keeps its subunit until a new transaction arrives
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !txn_start) |=> (locked_q && $stable(lock_beat_q)));

endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank #(
    parameter int N = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst)            bit_q <= 1'b0;
            else if (set_in[i]) bit_q <= 1'b1;
            else if (clr_in[i]) bit_q <= 1'b0;
        end

        assign q[i] = bit_q;

        // R1, R3: a set is seen in the next cycle even against a clear
        assert_set_lands_R3: assert property (@(posedge clk) disable iff (rst)
            set_in[i] |=> q[i]);

        // R2: a clear with no set empties the bit
        assert_clear_lands_R2: assert property (@(posedge clk) disable iff (rst)
            (clr_in[i] && !set_in[i]) |=> !q[i]);

        // R1: without a clear the bit never falls
        assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !clr_in[i]) |=> q[i]);
    end

endmodule

// File: rtl/fsr_flag_unit.sv
module fsr_flag_unit #(
    parameter int N = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] accepted,
    input  logic [N-1:0] serious,
    input  logic [N-1:0] sticky_q,
    input  logic         priv_in,
    input  logic         clr_multi,
    input  logic         clr_priv,
    output logic         multi_q,
    output logic         priv_q
);

    logic repeat_hit;
    logic any_logged;

    assign repeat_hit = |(accepted & serious & sticky_q);
    assign any_logged = |accepted;

    always_ff @(posedge clk) begin
        if (rst) begin
            multi_q <= 1'b0;
            priv_q  <= 1'b0;
        end else begin
            if (repeat_hit)     multi_q <= 1'b1;
            else if (clr_multi) multi_q <= 1'b0;

            if (any_logged)     priv_q <= priv_in;
            else if (clr_priv)  priv_q <= 1'b0;
        end
    end

    // R4, R5: the flag rises only on a serious repeat of a set type
    assert_multi_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (!multi_q && !(|(accepted & serious & sticky_q))) |=> !multi_q);

    // R4: a serious repeat is flagged in the next cycle
    assert_multi_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (|(accepted & serious & sticky_q)) |=> multi_q);

    // R7: privilege follows the input of the logging cycle
    assert_priv_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (|accepted) |=> (priv_q == $past(priv_in)));

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fsr_pkg::*;
#(
    parameter int NUM_TYPES = fsr_pkg::N_TYPES,
    parameter int SUB_UNITS = fsr_pkg::SUBUNITS,
    parameter logic [NUM_TYPES-1:0] BUS_ECC_MASK = fsr_pkg::BUS_ECC_TYPES,
    localparam int BEAT_W  = (SUB_UNITS > 1) ? $clog2(SUB_UNITS) : 1,
    localparam int CLS_W   = 2 * NUM_TYPES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_TYPES-1:0]    err_valid,
    input  logic [CLS_W-1:0]        err_cls,
    input  logic [BEAT_W-1:0]       err_beat,
    input  logic                    txn_start,
    input  logic                    priv_in,
    input  logic [MSYN_W-1:0]       msyn_in,
    input  logic [ESYN_W-1:0]       esyn_in,
    input  logic                    sw_wr,
    input  logic [REG_W-1:0]        sw_wdata,
    output logic [REG_W-1:0]        status,
    output logic                    any_err
);

    fsr_word_t             wr_word;
    fsr_word_t             rd_word;
    logic [NUM_TYPES-1:0]  accepted;
    logic [NUM_TYPES-1:0]  serious;
    logic [NUM_TYPES-1:0]  sticky_q;
    logic [NUM_TYPES-1:0]  sticky_clr;
    logic                  multi_q;
    logic                  priv_q;
    logic                  sw_flag_q;

    assign wr_word    = fsr_word_t'(sw_wdata);
    assign sticky_clr = sw_wr ? wr_word.sticky : '0;

    for (genvar i = 0; i < NUM_TYPES; i++) begin : g_cls
        assign serious[i] = cls_is_serious(err_cls[2*i +: 2]);
    end

    fsr_beat_filter #(
        .N        (NUM_TYPES),
        .SUBUNITS (SUB_UNITS),
        .BUS_MASK (BUS_ECC_MASK)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .txn_start (txn_start),
        .beat      (err_beat),
        .raw_valid (err_valid),
        .accepted  (accepted)
    );

    fsr_sticky_bank #(
        .N (NUM_TYPES)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_in (accepted),
        .clr_in (sticky_clr),
        .q      (sticky_q)
    );

    fsr_flag_unit #(
        .N (NUM_TYPES)
    ) u_flags (
        .clk       (clk),
        .rst       (rst),
        .accepted  (accepted),
        .serious   (serious),
        .sticky_q  (sticky_q),
        .priv_in   (priv_in),
        .clr_multi (sw_wr && wr_word.multi),
        .clr_priv  (sw_wr && wr_word.priv),
        .multi_q   (multi_q),
        .priv_q    (priv_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        sw_flag_q <= 1'b0;
        else if (sw_wr) sw_flag_q <= wr_word.sw_flag;
    end

    always_comb begin
        rd_word         = '0;
        rd_word.sw_flag = sw_flag_q;
        rd_word.multi   = multi_q;
        rd_word.priv    = priv_q;
        rd_word.sticky  = sticky_q;
        rd_word.msyn    = msyn_in;
        rd_word.esyn    = esyn_in;
    end

    assign status  = rd_word;
    assign any_err = |sticky_q;

    // R9: the software flag follows the last written value
    assert_sw_flag_R9: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (status[REG_W-1] == $past(sw_wdata[REG_W-1])));

    // R8: syndrome views track their inputs whatever is written
    assert_syn_view_R8: assert property (@(posedge clk) disable iff (rst)
        (status[ESYN_W-1:0] == esyn_in) && (status[16 +: MSYN_W] == msyn_in));

endmodule

// File: tb/sim_fault_status_reg.sv
module sim_fault_status_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] err_valid = '0;
    logic [37:0] err_cls = '0;
    logic [1:0]  err_beat = '0;
    logic        txn_start = 1'b0;
    logic        priv_in = 1'b0;
    logic [3:0]  msyn_in = '0;
    logic [8:0]  esyn_in = '0;
    logic        sw_wr = 1'b0;
    logic [63:0] sw_wdata = '0;
    logic [63:0] status;
    logic        any_err;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [63:0] RSV = 64'h7FC0_0001_FFF0_FE00;

    always #10 clk = ~clk;

    fault_status_reg u0 (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_cls(err_cls),
        .err_beat(err_beat), .txn_start(txn_start), .priv_in(priv_in),
        .msyn_in(msyn_in), .esyn_in(esyn_in), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .status(status), .any_err(any_err)
    );

    function automatic logic [63:0] b(input int n);
        return 64'd1 << n;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        err_valid = '0;
        txn_start = 1'b0;
        sw_wr     = 1'b0;
    endtask

    task automatic ev(input int idx, input logic [1:0] cls, input logic [1:0] beat, input logic txn);
        err_valid[idx]       = 1'b1;
        err_cls[2*idx +: 2]  = cls;
        err_beat             = beat;
        txn_start            = txn;
        step();
    endtask

    task automatic wr(input logic [63:0] d);
        sw_wr    = 1'b1;
        sw_wdata = d;
        step();
    endtask

    task automatic t_reset();
        check("R1 reset word", status, 64'd0);
        check("R10 reset any_err", {63'd0, any_err}, 64'd0);
    endtask

    task automatic t_set_and_multi();
        ev(5, 2'b00, 2'd0, 1'b1);
        check("R1 type5 sets bit38", status, b(38));
        check("R10 any_err high", {63'd0, any_err}, 64'd1);
        ev(5, 2'b00, 2'd0, 1'b1);
        check("R5 hw repeat no multi", status, b(38));
        ev(5, 2'b10, 2'd0, 1'b1);
        check("R4 fatal repeat sets multi", status, b(38) | b(53));
        wr(b(38) | b(53));
        check("R4 multi and bit cleared", status, 64'd0);
        ev(5, 2'b01, 2'd0, 1'b1);
        ev(5, 2'b01, 2'd0, 1'b1);
        check("R4 sw-fix repeat sets multi", status, b(38) | b(53));
        wr(b(38) | b(53));
    endtask

    task automatic t_clear_rules();
        ev(7, 2'b00, 2'd0, 1'b1);
        ev(8, 2'b00, 2'd0, 1'b1);
        wr(b(40));
        check("R2 only written bit clears", status, b(41));
        err_valid[8]       = 1'b1;
        err_cls[17:16]     = 2'b00;
        sw_wr              = 1'b1;
        sw_wdata           = b(41);
        step();
        check("R3 set beats clear", status, b(41));
        wr(b(41));
        check("R2 cleared to zero", status, 64'd0);
    endtask

    task automatic t_priv();
        priv_in = 1'b1;
        ev(7, 2'b00, 2'd0, 1'b1);
        check("R7 priv captured", status, b(40) | b(52));
        priv_in = 1'b0;
        wr(b(52));
        check("R7 priv cleared", status, b(40));
        wr(b(40));
    endtask

    task automatic t_filter();
        ev(0, 2'b00, 2'd0, 1'b1);
        check("R6 first bus beat logged", status, b(33));
        ev(0, 2'b10, 2'd1, 1'b0);
        check("R6 later beat dropped, no multi", status, b(33));
        ev(1, 2'b10, 2'd2, 1'b0);
        check("R6 later beat bus type dropped", status, b(33));
        ev(5, 2'b00, 2'd2, 1'b0);
        check("R6 non-bus type kept", status, b(33) | b(38));
        ev(1, 2'b10, 2'd3, 1'b1);
        check("R6 new txn logs again", status, b(33) | b(34) | b(38));
        wr(b(33) | b(34) | b(38));
    endtask

    task automatic t_fields();
        msyn_in = 4'hA;
        esyn_in = 9'h155;
        ev(18, 2'b00, 2'd0, 1'b1);
        wr('1);
        check("R8 syndromes unchanged by write", status & 64'h0000_0000_000F_01FF, 64'h0000_0000_000A_0155);
        check("R9 flag written to one", status & b(63), b(63));
        check("R9 reserved bits zero", status & RSV, 64'd0);
        check("R2 write ones clears sticky", status & 64'h000F_FFFE_0000_0000, 64'd0);
        check("R10 any_err low after clear", {63'd0, any_err}, 64'd0);
        wr(64'd0);
        check("R9 flag written to zero", status & b(63), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_and_multi();
        t_clear_rules();
        t_priv();
        t_filter();
        t_fields();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule